// File: doc/BRIEF.md
# Half-Bridge Gate Interlock Controller

This block drives the two gate enables of one half-bridge leg from a low-side command, a high-side command, a disable input and an undervoltage flag. It applies a fixed priority: a fault (disable or undervoltage) turns both switches off, a low-side command wins over a high-side command, and the high side conducts only when it alone is requested. A full bridge uses two instances.

Turn-on of each switch waits for its own run-time dead time, given in clock cycles. The wait starts only once the opposite gate is already low. Turn-off is never delayed. Two parameters set a minimum turn-on request length and a minimum off time, so very short command pulses are absorbed.

When a fault clears, a start-up sequence runs. The low-side gate is pulsed on for a fixed refresh interval. The high side cannot be requested until a longer upper-enable interval has passed. If the fault returns during the sequence, the sequence is abandoned and starts again from the beginning on the next release.

All four control inputs pass through two synchronizer stages and the gates are registered. Edge numbers below count rising clock edges: edge 0 is the first edge that samples a changed input.

Top module: `hb_leg_ctrl`

## Requirements
- R1: While rst_n is low, lo_gate and hi_gate are low. The disable and undervoltage synchronizer stages leave reset reading asserted, so after reset both gates stay low for as long as dis is held high.
- R2: If dis or uv is high, both gates are low from edge 2 onward, whatever the command inputs are.
- R3: With no fault, a high lo_cmd turns lo_gate on and keeps hi_gate off, even when hi_cmd is also high. lo_gate and hi_gate are never high in the same cycle.
- R4: hi_gate is high only when hi_cmd is high, lo_cmd is low and the start-up sequence has completed. With both commands low, both gates are low.
- R5: A turn-on request applied from an idle state, with the opposite gate already low, raises the gate at edge 2+N. N is the larger of that side's programmed delay (lo_dly or hi_dly) and MIN_ON_CYC. A gate only rises when the opposite gate was low in the previous cycle.
- R6: When a gate's command drops, the gate falls at edge 2, with no programmed delay.
- R7: Alternating mode: with hi_cmd held high, lo_cmd alone swaps the gates. When lo_cmd falls, lo_gate falls at edge 2 and hi_gate rises at edge 3+N_hi. When lo_cmd rises, hi_gate falls at edge 2 and lo_gate rises at edge 3+N_lo.
- R8: A turn-on request that is withdrawn before its delay has run out produces no pulse on the gate.
- R9: After a gate falls, it stays low for at least MIN_OFF_CYC+1 cycles, even if its command returns sooner.
- R10: When the fault clears, lo_gate is forced high from edge 2 for exactly REFRESH_CYC cycles, whatever lo_cmd is. If lo_cmd is low, lo_gate falls at edge 2+REFRESH_CYC.
- R11: After the fault clears, with hi_cmd high and lo_cmd low, hi_gate rises at edge 2+UPEN_CYC+N_hi. UPEN_CYC must exceed REFRESH_CYC.
- R12: If a fault returns during the start-up sequence, the gates drop. On the next release a complete refresh pulse runs again, timed from that release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_cmd | input | 1 | Low-side switch request |
| hi_cmd | input | 1 | High-side switch request |
| dis | input | 1 | Disable; forces both gates off |
| uv | input | 1 | Undervoltage flag; forces both gates off |
| lo_dly | input | DLY_W | Low-side turn-on dead time in cycles |
| hi_dly | input | DLY_W | High-side turn-on dead time in cycles |
| lo_gate | output | 1 | Low-side gate enable |
| hi_gate | output | 1 | High-side gate enable |

## Verification
The bench builds the block with DLY_W=6, MIN_ON_CYC=3, MIN_OFF_CYC=6, REFRESH_CYC=8 and UPEN_CYC=12. These short intervals make each start-up phase, the restart after an interrupted sequence, and the minimum-off hold observable edge by edge within a few dozen cycles. A dead time of zero lets the MIN_ON_CYC floor decide the turn-on wait. Dead times of 5 and 7 make the two sides' waits distinct, so an exchange between them shows up as a wrong edge number.

// File: rtl/hb_leg_pkg.sv
package hb_leg_pkg;
    // Start-up phase of the leg after a fault releases.
    typedef enum logic [1:0] {
        PH_HOLD    = 2'd0,
        PH_REFRESH = 2'd1,
        PH_SETTLE  = 2'd2,
        PH_RUN     = 2'd3
    } hb_phase_e;
endpackage

// File: rtl/hb_sync.sv
// Two-stage synchronizer with a per-instance reset value.
module hb_sync #(
    parameter int         W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.meta = d;
        sy_d.stab = sy_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '{meta: RST_VAL, stab: RST_VAL};
        end else begin
            sy_q <= sy_d;
        end
    end

    assign q = sy_q.stab;
endmodule

// File: rtl/hb_start.sv
// Start-up sequencer: refresh pulse on the low side, then upper enable.
module hb_start
    import hb_leg_pkg::*;
#(
    parameter int REFRESH_CYC = 41,
    parameter int UPEN_CYC    = 45
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flt,
    output logic force_lo,
    output logic hi_ok
);
    localparam int ST_W = $clog2(UPEN_CYC + 2);
    localparam logic [ST_W-1:0] REF_L  = ST_W'(REFRESH_CYC);
    localparam logic [ST_W-1:0] UPEN_L = ST_W'(UPEN_CYC);

    typedef struct packed {
        logic [ST_W-1:0] cnt;
    } start_t;

    start_t    st_d, st_q;
    hb_phase_e phase;

    always_comb begin
        st_d = st_q;
        if (flt) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != UPEN_L) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        if (flt) begin
            phase = PH_HOLD;
        end else if (st_q.cnt < REF_L) begin
            phase = PH_REFRESH;
        end else if (st_q.cnt < UPEN_L) begin
            phase = PH_SETTLE;
        end else begin
            phase = PH_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign force_lo = (phase == PH_REFRESH);
    assign hi_ok    = (phase == PH_RUN);
endmodule

// File: rtl/hb_side.sv
// One switch: delayed turn-on, immediate turn-off, minimum off time.
module hb_side #(
    parameter int DLY_W       = 8,
    parameter int MIN_ON_CYC  = 5,
    parameter int MIN_OFF_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             want,
    input  logic             other_on,
    input  logic             force_on,
    input  logic [DLY_W-1:0] dly,
    output logic             gate
);
    localparam int OFF_W = $clog2(MIN_OFF_CYC + 2);
    localparam logic [DLY_W-1:0] MIN_ON_L = DLY_W'(MIN_ON_CYC);
    localparam logic [DLY_W-1:0] PEND_MAX = '1;
    localparam logic [OFF_W-1:0] OFF_L    = OFF_W'(MIN_OFF_CYC);

    typedef struct packed {
        logic             gate;
        logic [DLY_W-1:0] pend;
        logic [OFF_W-1:0] offc;
    } side_t;

    side_t            sd_d, sd_q;
    logic [DLY_W-1:0] need;
    logic             arm;

    always_comb begin
        need = (dly > MIN_ON_L) ? dly : MIN_ON_L;
        arm  = want && !other_on;
        sd_d = sd_q;
        if (force_on) begin
            sd_d.gate = 1'b1;
            sd_d.pend = '0;
            sd_d.offc = '0;
        end else if (sd_q.gate) begin
            sd_d.pend = '0;
            sd_d.offc = '0;
            if (!want) begin
                sd_d.gate = 1'b0;
            end
        end else begin
            if (sd_q.offc != OFF_L) begin
                sd_d.offc = sd_q.offc + 1'b1;
            end
            if (arm) begin
                if ((sd_q.pend >= need) && (sd_q.offc >= OFF_L)) begin
                    sd_d.gate = 1'b1;
                end
                if (sd_q.pend != PEND_MAX) begin
                    sd_d.pend = sd_q.pend + 1'b1;
                end
            end else begin
                sd_d.pend = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sd_q <= '{gate: 1'b0, pend: '0, offc: '0};
        end else begin
            sd_q <= sd_d;
        end
    end

    assign gate = sd_q.gate;
endmodule

// File: rtl/hb_leg_ctrl.sv
// Half-bridge leg controller: priority, dead time, start-up sequence.
module hb_leg_ctrl #(
    parameter int DLY_W       = 8,
    parameter int MIN_ON_CYC  = 5,
    parameter int MIN_OFF_CYC = 4,
    parameter int REFRESH_CYC = 41,
    parameter int UPEN_CYC    = 45
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_cmd,
    input  logic             hi_cmd,
    input  logic             dis,
    input  logic             uv,
    input  logic [DLY_W-1:0] lo_dly,
    input  logic [DLY_W-1:0] hi_dly,
    output logic             lo_gate,
    output logic             hi_gate
);
    localparam int NSIDE = 2;

    logic [1:0]       cmd_s;     // [0] low, [1] high
    logic [1:0]       flt_v;     // [0] disable, [1] undervoltage
    logic             flt_s;
    logic             force_lo;
    logic             hi_ok;
    logic [NSIDE-1:0] want;
    logic [NSIDE-1:0] gate;
    logic [NSIDE-1:0] force_v;
    logic [DLY_W-1:0] dly_v [NSIDE];

    hb_sync #(.W(2), .RST_VAL(2'b00)) u_cmd_sync (
        .clk(clk), .rst_n(rst_n), .d({hi_cmd, lo_cmd}), .q(cmd_s)
    );

    hb_sync #(.W(2), .RST_VAL(2'b11)) u_flt_sync (
        .clk(clk), .rst_n(rst_n), .d({uv, dis}), .q(flt_v)
    );

    assign flt_s = |flt_v;

    hb_start #(.REFRESH_CYC(REFRESH_CYC), .UPEN_CYC(UPEN_CYC)) u_start (
        .clk(clk), .rst_n(rst_n), .flt(flt_s), .force_lo(force_lo), .hi_ok(hi_ok)
    );

    assign want[0]  = !flt_s && cmd_s[0];
    assign want[1]  = hi_ok && cmd_s[1] && !cmd_s[0];
    assign force_v  = {1'b0, force_lo};
    assign dly_v[0] = lo_dly;
    assign dly_v[1] = hi_dly;

    for (genvar i = 0; i < NSIDE; i++) begin : g_side
        hb_side #(
            .DLY_W(DLY_W), .MIN_ON_CYC(MIN_ON_CYC), .MIN_OFF_CYC(MIN_OFF_CYC)
        ) u_side (
            .clk(clk),
            .rst_n(rst_n),
            .want(want[i]),
            .other_on(gate[NSIDE-1-i]),
            .force_on(force_v[i]),
            .dly(dly_v[i]),
            .gate(gate[i])
        );
    end

    assign lo_gate = gate[0];
    assign hi_gate = gate[1];
endmodule

// File: rtl/hb_leg_chk.sv
module hb_leg_chk (
    input logic clk,
    input logic rst_n,
    input logic lo_gate,
    input logic hi_gate,
    input logic flt_s,
    input logic c_lo,
    input logic c_hi
);
    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n) !(lo_gate && hi_gate)); // R3
    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n) flt_s |=> (!lo_gate && !hi_gate)); // R2
    AST_LO_WINS: assert property (@(posedge clk) disable iff (!rst_n) (c_lo && !flt_s) |=> !hi_gate); // R3
    AST_HI_RISE_LO_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(hi_gate) |-> !$past(lo_gate)); // R5
    AST_LO_RISE_HI_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(lo_gate) |-> !$past(hi_gate)); // R5
    AST_HI_DROP_FAST: assert property (@(posedge clk) disable iff (!rst_n) (hi_gate && !c_hi) |=> !hi_gate); // R6
endmodule

bind hb_leg_ctrl hb_leg_chk u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .lo_gate(lo_gate),
    .hi_gate(hi_gate),
    .flt_s(flt_s),
    .c_lo(cmd_s[0]),
    .c_hi(cmd_s[1])
);

// File: tb/tb_hb_leg_ctrl.sv
module tb_hb_leg_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lo_cmd = 1'b0, hi_cmd = 1'b0, dis = 1'b1, uv = 1'b0;
    logic [DW-1:0] lo_dly = '0, hi_dly = '0;
    logic          lo_gate, hi_gate;

    int checks = 0;
    int errors = 0;
    int edge_no = 0;
    bit done = 1'b0;

    hb_leg_ctrl #(
        .DLY_W(DW), .MIN_ON_CYC(3), .MIN_OFF_CYC(6), .REFRESH_CYC(8), .UPEN_CYC(12)
    ) dut (
        .clk(clk), .rst_n(rst_n), .lo_cmd(lo_cmd), .hi_cmd(hi_cmd), .dis(dis), .uv(uv),
        .lo_dly(lo_dly), .hi_dly(hi_dly), .lo_gate(lo_gate), .hi_gate(hi_gate)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b (edge %0d)", req, act, exp, edge_no);
        end
    endtask

    // Inputs were just changed at a falling edge; next rising edge is edge 0.
    task automatic mark();
        edge_no = -1;
    endtask

    task automatic step_to(input int e);
        while (edge_no < e) begin
            @(posedge clk);
            edge_no++;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 lo in reset", lo_gate, 1'b0);
        chk("R1 hi in reset", hi_gate, 1'b0);
        idle(3);
        rst_n = 1'b1;
        idle(6);
        chk("R1 lo after reset, dis high", lo_gate, 1'b0);
        chk("R1 hi after reset, dis high", hi_gate, 1'b0);
    endtask

    task automatic t_startup_hi();
        hi_dly = 6'd2; lo_cmd = 1'b0; hi_cmd = 1'b1;
        dis = 1'b0; mark();
        step_to(1);  chk("R10 lo before refresh", lo_gate, 1'b0);
        step_to(2);  chk("R10 lo refresh starts", lo_gate, 1'b1);
        step_to(9);  chk("R10 lo refresh last cycle", lo_gate, 1'b1);
        chk("R11 hi held during refresh", hi_gate, 1'b0);
        step_to(10); chk("R10 lo refresh ends", lo_gate, 1'b0);
        step_to(16); chk("R11 hi before upper enable", hi_gate, 1'b0);
        step_to(17); chk("R11 hi after upper enable", hi_gate, 1'b1);
        idle(10);
    endtask

    task automatic t_fault_dis();
        dis = 1'b1; mark();
        step_to(1); chk("R2 hi before dis seen", hi_gate, 1'b1);
        step_to(2); chk("R2 hi forced off by dis", hi_gate, 1'b0);
        lo_cmd = 1'b1;
        step_to(8);
        chk("R2 lo off under dis with lo_cmd", lo_gate, 1'b0);
        chk("R2 hi off under dis with hi_cmd", hi_gate, 1'b0);
    endtask

    task automatic t_startup_lo_held();
        lo_cmd = 1'b1; hi_cmd = 1'b0;
        dis = 1'b0; mark();
        step_to(2);  chk("R10 refresh with lo_cmd high", lo_gate, 1'b1);
        step_to(12); chk("R10 lo stays on after refresh", lo_gate, 1'b1);
        step_to(20); chk("R4 hi off, hi_cmd low", hi_gate, 1'b0);
        idle(10);
    endtask

    task automatic t_off_and_on();
        lo_dly = 6'd5; hi_dly = 6'd7;
        lo_cmd = 1'b0; mark();
        step_to(1); chk("R6 lo before drop", lo_gate, 1'b1);
        step_to(2); chk("R6 lo drops without delay", lo_gate, 1'b0);
        idle(20);
        lo_cmd = 1'b1; mark();
        step_to(6); chk("R5 lo before dead time", lo_gate, 1'b0);
        step_to(7); chk("R5 lo after dead time", lo_gate, 1'b1);
        lo_cmd = 1'b0; idle(20);
        hi_cmd = 1'b1; mark();
        step_to(8); chk("R5 hi before dead time", hi_gate, 1'b0);
        step_to(9); chk("R5 hi after dead time", hi_gate, 1'b1);
        idle(5);
    endtask

    task automatic t_bistate();
        // hi_cmd held high, hi_gate currently on
        lo_cmd = 1'b1; mark();
        step_to(1); chk("R7 hi before swap", hi_gate, 1'b1);
        step_to(2); chk("R7 hi off on lo_cmd rise", hi_gate, 1'b0);
        step_to(7); chk("R7 lo waits its dead time", lo_gate, 1'b0);
        step_to(8); chk("R7 lo on after dead time", lo_gate, 1'b1);
        idle(20);
        lo_cmd = 1'b0; mark();
        step_to(2);  chk("R7 lo off on lo_cmd fall", lo_gate, 1'b0);
        step_to(9);  chk("R7 hi waits its dead time", hi_gate, 1'b0);
        step_to(10); chk("R7 hi on after dead time", hi_gate, 1'b1);
        idle(5);
    endtask

    task automatic t_priority();
        hi_cmd = 1'b0; lo_cmd = 1'b0; idle(5);
        mark(); step_to(2);
        chk("R4 both off, commands low (lo)", lo_gate, 1'b0);
        chk("R4 both off, commands low (hi)", hi_gate, 1'b0);
        idle(20);
        hi_cmd = 1'b1; lo_cmd = 1'b1; mark();
        begin
            bit hi_seen = 1'b0;
            while (edge_no < 20) begin
                step_to(edge_no + 1);
                if (hi_gate) hi_seen = 1'b1;
            end
            chk("R3 hi never on with both commands", hi_seen, 1'b0);
        end
        chk("R3 lo on with both commands", lo_gate, 1'b1);
        hi_cmd = 1'b0; idle(5);
    endtask

    task automatic t_min_off();
        lo_dly = 6'd0;
        lo_cmd = 1'b0; mark();
        step_to(0); lo_cmd = 1'b1;
        step_to(2); chk("R9 lo drops on short gap", lo_gate, 1'b0);
        step_to(8); chk("R9 lo held off min time", lo_gate, 1'b0);
        step_to(9); chk("R9 lo back on after min off", lo_gate, 1'b1);
        lo_cmd = 1'b0; idle(20);
    endtask

    task automatic t_cancel();
        lo_dly = 6'd10;
        lo_cmd = 1'b1; mark();
        step_to(4); lo_cmd = 1'b0;
        begin
            bit seen = 1'b0;
            while (edge_no < 24) begin
                step_to(edge_no + 1);
                if (lo_gate) seen = 1'b1;
            end
            chk("R8 cancelled lo turn-on", seen, 1'b0);
        end
        lo_dly = 6'd0;
        lo_cmd = 1'b1; mark();
        step_to(1); lo_cmd = 1'b0;
        begin
            bit seen = 1'b0;
            while (edge_no < 15) begin
                step_to(edge_no + 1);
                if (lo_gate) seen = 1'b1;
            end
            chk("R8 pulse below min on absorbed", seen, 1'b0);
        end
        idle(10);
    endtask

    task automatic t_uv();
        hi_dly = 6'd2; hi_cmd = 1'b1; lo_cmd = 1'b0; idle(20);
        chk("R4 hi on before uv", hi_gate, 1'b1);
        uv = 1'b1; mark();
        step_to(1); chk("R2 hi before uv seen", hi_gate, 1'b1);
        step_to(2); chk("R2 hi off by uv", hi_gate, 1'b0);
        hi_cmd = 1'b0; idle(10);
        uv = 1'b0; mark();
        step_to(2);  chk("R10 refresh after uv release", lo_gate, 1'b1);
        step_to(10); chk("R10 refresh ends after uv", lo_gate, 1'b0);
        idle(10);
    endtask

    task automatic t_restart();
        dis = 1'b1; idle(10);
        dis = 1'b0; mark();
        step_to(2); chk("R12 first refresh starts", lo_gate, 1'b1);
        step_to(3); dis = 1'b1;
        step_to(5); dis = 1'b0;
        step_to(6);  chk("R12 refresh aborted", lo_gate, 1'b0);
        step_to(7);  chk("R12 off until release seen", lo_gate, 1'b0);
        step_to(8);  chk("R12 refresh restarts", lo_gate, 1'b1);
        step_to(15); chk("R12 full refresh length", lo_gate, 1'b1);
        step_to(16); chk("R12 restarted refresh ends", lo_gate, 1'b0);
        idle(10);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_startup_hi();
        t_fault_dis();
        t_startup_lo_held();
        t_off_and_on();
        t_bistate();
        t_priority();
        t_min_off();
        t_cancel();
        t_uv();
        t_restart();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule